// File: doc/BRIEF.md
# Converter-side chip-select serial port

This block models, cycle by cycle, the digital read-out port of a successive-approximation converter used in 4-wire chip-select mode with no busy indication. A rising convert strobe, taken while the active-low select line is high, captures an 18-bit sample word and starts a conversion of fixed length, counted in system clocks. When the conversion ends, the port waits in standby holding the result. A host then pulls select low to bring the result out serially, most significant bit first, stepping one bit per falling serial-clock edge.

The serial data line comes with an output-enable so that a pad or a shared bus can tri-state it. It is released after the last bit, or earlier if select goes high again, so several such ports can share one data wire. The convert strobe, select and serial clock are sampled in the system clock domain, and every output is registered.

Top module: `cs_serial_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the output-enable is low (data line in high impedance) and the data line reads 0.
- R2: A rising convert strobe while select is high starts a conversion, captures `sample_i`, and leaves the output-enable low from the next clock on.
- R3: With no conversion in progress and no result pending (idle), select low together with convert low drives the data line to 0 with output-enable high one cycle later.
- R4: A conversion lasts `CONV_CYC` clocks after the starting edge. Select falls and serial-clock falls during that time load nothing: the output stays in high impedance, also after the conversion ends, until a new select fall.
- R5: In standby, a falling select puts bit 17 of the held word on the data line, with output-enable high, one cycle later.
- R6: While shifting, each falling serial-clock edge presents the next lower bit one cycle later, down to bit 0. Between falls the data line does not change.
- R7: The 18th falling serial-clock edge of a read releases the data line (output-enable low) one cycle later.
- R8: A rising select releases the data line one cycle later, even in the middle of a word. A later select fall does not repeat the word.
- R9: A rising convert strobe (select high) during standby discards the held result and starts a new conversion with the present `sample_i`.
- R10: If select stays low past the 18th fall, further serial-clock falls keep the output in high impedance and the word is not sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_i | input | 1 | Convert strobe; rising edge starts a conversion |
| sel_n_i | input | 1 | Select, active low; level at convert edge picks chip-select mode |
| sclk_i | input | 1 | Serial clock from the host |
| sample_i | input | WORD_W | Sample word captured when a conversion starts |
| sdo_o | output | 1 | Serial data line value |
| sdo_oe_o | output | 1 | Enable for the data line; low means high impedance |

## Verification
Each input is sampled once and the outputs are registered, so every response (release, drive-low, MSB, next bit) is due exactly one system clock after the edge that caused it. Standby is due `CONV_CYC` clocks after the convert edge. The bench changes inputs just after a falling clock edge and checks the outputs at the next falling edge. A select fall placed one clock before the end of conversion checks the exact boundary, and a fall in the clock after it checks that the result comes out.

// File: rtl/csport_pkg.sv
package csport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_STBY  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONE  = 3'd4
  } port_state_t;
endpackage

// File: rtl/csport_edges.sv
module csport_edges #(
  parameter int         N    = 3,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= INIT[i];
      else     prev_q[i] <= d[i];
    end
    assign rise[i] = d[i] & ~prev_q[i];
    assign fall[i] = ~d[i] & prev_q[i];
  end
endmodule

// File: rtl/csport_timer.sv
module csport_timer #(
  parameter int CONV_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign done = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/csport_shifter.sv
module csport_shifter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb,
  output logic         next_msb
);
  logic [W-1:0] sh_q;

  assign msb      = sh_q[W-1];
  assign next_msb = sh_q[W-2];

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/cs_serial_port.sv
module cs_serial_port
  import csport_pkg::*;
#(
  parameter int WORD_W   = 18,
  parameter int CONV_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_i,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  logic [2:0] rise, fall;
  logic conv_rise, sel_fall, sel_rise, sclk_fall;
  logic t_start, t_done, sh_shift, sh_msb, sh_next;

  port_state_t   state_q, state_n;
  logic [BW-1:0] cnt_q, cnt_n;
  logic          sdo_n, oe_n;

  csport_edges #(.N(3), .INIT(3'b010)) u_edges (
    .clk(clk), .rst(rst), .d({sclk_i, sel_n_i, conv_i}),
    .rise(rise), .fall(fall)
  );

  assign conv_rise = rise[0];
  assign sel_rise  = rise[1];
  assign sel_fall  = fall[1];
  assign sclk_fall = fall[2];

  csport_timer #(.CONV_CYC(CONV_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .done(t_done)
  );

  csport_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(t_start), .din(sample_i),
    .shift(sh_shift), .msb(sh_msb), .next_msb(sh_next)
  );

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    t_start  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (conv_rise && sel_n_i) begin
          t_start = 1'b1;
          state_n = ST_CONV;
        end
      end
      ST_CONV: begin
        if (t_done) state_n = ST_STBY;
      end
      ST_STBY: begin
        if (conv_rise && sel_n_i) begin
          t_start = 1'b1;
          state_n = ST_CONV;
        end else if (sel_fall) begin
          cnt_n   = '0;
          state_n = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sel_rise) begin
          state_n = ST_IDLE;
        end else if (sclk_fall) begin
          if (cnt_q == LAST_BIT) begin
            state_n = ST_DONE;
          end else begin
            sh_shift = 1'b1;
            cnt_n    = cnt_q + 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (sel_rise) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase

    oe_n  = (state_n == ST_SHIFT) ||
            ((state_n == ST_IDLE) && !sel_n_i && !conv_i);
    sdo_n = (state_n == ST_SHIFT) && (sh_shift ? sh_next : sh_msb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      sdo_o    <= sdo_n;
      sdo_oe_o <= oe_n;
    end
  end
endmodule

// File: rtl/cs_serial_port_chk.sv
module cs_serial_port_chk
  import csport_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        conv_i,
  input logic        sel_n_i,
  input logic        sclk_i,
  input logic        sdo_o,
  input logic        sdo_oe_o,
  input port_state_t state_q,
  input logic        held_msb
);
  // R2
  assert_conv_start_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(conv_i) && sel_n_i) |=> !sdo_oe_o);

  // R3
  assert_idle_drive_low_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !sel_n_i && !conv_i) |=> (sdo_oe_o && !sdo_o));

  // R4
  assert_conv_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV) |-> !sdo_oe_o);

  // R5
  assert_msb_first_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STBY && $fell(sel_n_i)) |=> (sdo_oe_o && sdo_o == $past(held_msb)));

  // R6
  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT && !$fell(sclk_i) && !$rose(sel_n_i)) |=> $stable(sdo_o));

  // R8
  assert_sel_release_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n_i) |=> !sdo_oe_o);

  // R10
  assert_no_repeat_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |-> !sdo_oe_o);
endmodule

bind cs_serial_port cs_serial_port_chk u_chk (
  .clk(clk), .rst(rst), .conv_i(conv_i), .sel_n_i(sel_n_i), .sclk_i(sclk_i),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .state_q(state_q), .held_msb(sh_msb)
);

// File: tb/cs_serial_port_test.sv
module cs_serial_port_test;
  localparam int W = 18;
  localparam int C = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv = 1'b0;
  logic         sel_n = 1'b1;
  logic         sclk = 1'b0;
  logic [W-1:0] sample = '0;
  logic         sdo, oe;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  cs_serial_port #(.WORD_W(W), .CONV_CYC(C)) uut (
    .clk(clk), .rst(rst), .conv_i(conv), .sel_n_i(sel_n), .sclk_i(sclk),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(oe)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {oe,sdo} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic convert(input logic [W-1:0] s);
    sample = s;
    sel_n  = 1'b1;
    conv   = 1'b0;
    step();
    conv = 1'b1;
    step();
    check("R2", {oe, sdo}, 2'b00);
    repeat (C) step();
  endtask

  task automatic read_word(input logic [W-1:0] exp, input string req);
    sel_n = 1'b0;
    step();
    check("R5", {oe, sdo}, {1'b1, exp[W-1]});
    for (int i = W - 2; i >= 0; i--) begin
      sclk = 1'b1;
      step();
      check("R6", {oe, sdo}, {1'b1, exp[i+1]});
      sclk = 1'b0;
      step();
      check(req, {oe, sdo}, {1'b1, exp[i]});
    end
    sclk = 1'b1;
    step();
    sclk = 1'b0;
    step();
    check("R7", {oe, sdo}, 2'b00);
  endtask

  task automatic t_reset();
    repeat (3) step();
    check("R1", {oe, sdo}, 2'b00);
    rst = 1'b0;
    step();
    check("R1", {oe, sdo}, 2'b00);
  endtask

  task automatic t_idle_low();
    sel_n = 1'b0;
    conv  = 1'b0;
    step();
    check("R3", {oe, sdo}, 2'b10);
    sel_n = 1'b1;
    step();
    check("R3", {oe, sdo}, 2'b00);
  endtask

  task automatic t_basic_read(input logic [W-1:0] s);
    convert(s);
    read_word(s, "R6");
    sel_n = 1'b1;
    step();
    check("R8", {oe, sdo}, 2'b00);
    conv = 1'b0;
    step();
  endtask

  task automatic t_busy_select();
    sample = 18'h2AAAA;
    sel_n = 1'b1;
    conv = 1'b0;
    step();
    conv = 1'b1;
    step();
    sel_n = 1'b0;
    step();
    check("R4", {oe, sdo}, 2'b00);
    sel_n = 1'b1;
    step();
    sclk = 1'b1;
    step();
    sclk = 1'b0;
    step();
    repeat (C - 5) step();
    sel_n = 1'b0;
    step();
    check("R4", {oe, sdo}, 2'b00);
    step();
    check("R4", {oe, sdo}, 2'b00);
    sel_n = 1'b1;
    step();
    read_word(18'h2AAAA, "R4");
    sel_n = 1'b1;
    conv = 1'b0;
    step();
  endtask

  task automatic t_early_release();
    convert(18'h3C00F);
    sel_n = 1'b0;
    step();
    check("R5", {oe, sdo}, 2'b11);
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b1;
      step();
      sclk = 1'b0;
      step();
    end
    check("R6", {oe, sdo}, 2'b10);
    sel_n = 1'b1;
    step();
    check("R8", {oe, sdo}, 2'b00);
    sel_n = 1'b0;
    step();
    check("R8", {oe, sdo}, 2'b00);
    sel_n = 1'b1;
    conv = 1'b0;
    step();
  endtask

  task automatic t_reconvert();
    convert(18'h3FFFF);
    sample = 18'h05A3C;
    conv = 1'b0;
    step();
    conv = 1'b1;
    step();
    check("R9", {oe, sdo}, 2'b00);
    repeat (C) step();
    read_word(18'h05A3C, "R9");
    sel_n = 1'b1;
    conv = 1'b0;
    step();
  endtask

  task automatic t_overrun();
    convert(18'h20001);
    read_word(18'h20001, "R6");
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b1;
      step();
      sclk = 1'b0;
      step();
      check("R10", {oe, sdo}, 2'b00);
    end
    sel_n = 1'b1;
    step();
    check("R10", {oe, sdo}, 2'b00);
    conv = 1'b0;
    step();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_low();
    t_basic_read(18'h2D5A3);
    t_basic_read(18'h1B0F6);
    t_busy_select();
    t_early_release();
    t_reconvert();
    t_overrun();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule